// File: doc/BRIEF.md
# Masked Level Interrupt Combiner

The block gathers sixteen level-sensitive interrupt request lines from peripherals on a local bus and merges them into one request towards the processor. Each request line passes through a two-flop synchronizer into a status register, so a line held high keeps its status bit set and a line driven low clears it. A software-writable enable mask selects which status bits may raise the combined request. The combined request is registered.

Software reaches the block through a small register port with 16-bit data. The vector register is read-only. It returns a code for the lowest-numbered enabled source that is pending, and software uses that code directly as a dispatch offset. The mask register can be read and written. There is no per-source acknowledge. A source stops requesting when its peripheral drops its line, or when software disables it in the mask.

Top module: `masked_irq_ctrl`

## Requirements
- R1: A status bit is set while its request line is high and cleared while the line is low. The status register follows the line with three clock edges of delay: two synchronizer flops, then the status flop.
- R2: `irq_o` is high exactly when the AND of status and mask was nonzero at the previous clock edge.
- R3: A read at offset 0x000 returns (i+1)*4, where i is the lowest bit index set in status AND mask. It returns 0 when no such bit is set. Bits [1:0] of a nonzero code are always 0.
- R4: A read at offset 0x002 returns the mask. A write at offset 0x002 replaces all 16 mask bits with the write data. Bit n of the mask enables source n.
- R5: After reset the mask is 0x0010, which enables only source 4. After reset the status is 0 and `irq_o` is low.
- R6: A read at any offset other than 0x000 or 0x002 returns 0. A write to any offset other than 0x002, including 0x000, leaves the mask and `irq_o` unchanged.
- R7: A change on a request line appears in the vector after three clock edges and on `irq_o` after four. A mask write appears in the mask readback after one edge and on `irq_o` after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 16 | Level interrupt request lines, asynchronous |
| reg_we_i | input | 1 | Register write strobe, taken at the rising edge |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
The checker watches four things on every cycle. It checks that `irq_o` tracks the previous cycle's masked status. It checks that the status register equals the request lines from three edges earlier. It checks that every nonzero vector is a multiple of four and names an enabled pending source. It checks that mask writes land, that writes elsewhere leave the mask alone, and that unmapped offsets read zero.

Some properties are left to the bench scenarios. The bench shows that the lowest-index source wins when several are pending, across sweeps of source and mask patterns. It also confirms the reset mask value, and the exact latencies for request changes and for mask writes.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int unsigned NUM_SRC   = 16;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned SYNC_LEN  = 2;
  localparam int unsigned VEC_SHIFT = 2;
  localparam logic [ADDR_W-1:0] OFF_VEC  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_MASK = 12'h002;
  localparam logic [DATA_W-1:0] MASK_RST = 16'h0010;
endpackage

// File: rtl/mirq_sync.sv
module mirq_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= d_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
    end
  end

  assign q_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/mirq_prienc.sv
module mirq_prienc #(
  parameter int unsigned N     = 16,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned SHIFT = 2
) (
  input  logic [N-1:0]     pend_i,
  output logic [OUT_W-1:0] vec_o
);
  // lowest index wins: scan downwards so the last hit is the smallest
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = OUT_W'((i + 1) << SHIFT);
    end
  end
endmodule

// File: rtl/mirq_regs.sv
module mirq_regs
  import mirq_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] vec_i,
  output logic [NSRC-1:0]   mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NSRC-1:0] mask_q;
  logic            hit_mask;
  logic            hit_vec;

  assign hit_mask = (addr_i == OFF_MASK);
  assign hit_vec  = (addr_i == OFF_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mask_q <= MASK_RST[NSRC-1:0];
    else if (we_i && hit_mask)  mask_q <= wdata_i[NSRC-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (hit_vec)       rdata_o = vec_i;
    else if (hit_mask) rdata_o = DATA_W'(mask_q);
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/masked_irq_ctrl.sv
module masked_irq_ctrl
  import mirq_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   irq_src_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NSRC-1:0]   src_sync;
  logic [NSRC-1:0]   status_q;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   pend;
  logic [DATA_W-1:0] vec;
  logic              irq_q;

  mirq_sync #(.WIDTH(NSRC), .STAGES(SYNC_LEN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_src_i),
    .q_o   (src_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= src_sync;
  end

  assign pend = status_q & mask_q;

  mirq_prienc #(.N(NSRC), .OUT_W(DATA_W), .SHIFT(VEC_SHIFT)) u_enc (
    .pend_i(pend),
    .vec_o (vec)
  );

  mirq_regs #(.NSRC(NSRC)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .vec_i  (vec),
    .mask_o (mask_q),
    .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mirq_chk.sv
module mirq_chk
  import mirq_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   irq_src_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [NSRC-1:0]   status_q,
  input logic [NSRC-1:0]   mask_q
);
  logic [1:0]      up_cnt;
  logic [NSRC-1:0] pend;
  logic [3:0]      vec_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          up_cnt <= '0;
    else if (up_cnt != 3) up_cnt <= up_cnt + 2'd1;
  end

  assign pend    = status_q & mask_q;
  assign vec_idx = 4'((reg_rdata_o >> VEC_SHIFT) - 1);

  assert_status_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt == 2'd3) |-> (status_q == $past(irq_src_i, 3)));

  assert_irq_tracks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(pend != '0)));

  assert_vec_none_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFF_VEC && pend == '0) |-> (reg_rdata_o == '0));

  assert_vec_form_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFF_VEC && pend != '0) |->
      (reg_rdata_o[1:0] == 2'b00 && reg_rdata_o != '0 && pend[vec_idx]));

  assert_mask_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFF_MASK) |=> (mask_q == $past(reg_wdata_i[NSRC-1:0])));

  assert_reset_state_R5: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (mask_q == MASK_RST[NSRC-1:0] && !irq_o && status_q == '0));

  assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(reg_we_i && reg_addr_i == OFF_MASK)) |=> $stable(mask_q));

  assert_unmapped_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != OFF_VEC && reg_addr_i != OFF_MASK) |-> (reg_rdata_o == '0));
endmodule

bind masked_irq_ctrl mirq_chk #(.NSRC(NSRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_src_i  (irq_src_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .status_q   (status_q),
  .mask_q     (mask_q)
);

// File: tb/sim_masked_irq_ctrl.sv
`timescale 1ns/1ps
module sim_masked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] src = '0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  masked_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_src_i(src), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] exp_vec(input logic [15:0] p);
    logic [15:0] r = '0;
    for (int i = 15; i >= 0; i--) if (p[i]) r = 16'((i + 1) * 4);
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic settle;
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] m;
    logic [15:0] s;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5 reset state
    check("R5 irq", {15'b0, irq}, 16'h0);
    rd(12'h002, v); check("R5 mask", v, 16'h0010);
    rd(12'h000, v); check("R5 vec", v, 16'h0000);

    // default mask: source 3 blocked, source 4 passes
    src = 16'h0008; settle;
    rd(12'h000, v); check("R2 masked vec", v, 16'h0);
    check("R2 masked irq", {15'b0, irq}, 16'h0);
    src = 16'h0010; settle;
    rd(12'h000, v); check("R3 src4 vec", v, 16'h0014);
    check("R2 src4 irq", {15'b0, irq}, 16'h1);

    // R1 level low clears status
    src = 16'h0; settle;
    rd(12'h000, v); check("R1 cleared vec", v, 16'h0);
    check("R1 cleared irq", {15'b0, irq}, 16'h0);

    // R4 full mask write and readback
    wr(12'h002, 16'hFFFF);
    rd(12'h002, v); check("R4 readback", v, 16'hFFFF);

    // R3 single source sweep
    for (int i = 0; i < 16; i++) begin
      src = 16'(1 << i); settle;
      rd(12'h000, v); check("R3 single", v, 16'((i + 1) * 4));
      check("R2 single irq", {15'b0, irq}, 16'h1);
    end

    // R3/R4 mask sweep with all sources high
    src = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin
      wr(12'h002, 16'(1 << i)); settle;
      rd(12'h000, v); check("R4 mask select", v, 16'((i + 1) * 4));
    end

    // mixed patterns: lowest enabled pending wins
    for (int k = 0; k < 64; k++) begin
      s = 16'(k * 1031 + 7);
      m = ~16'(k * 517);
      src = s;
      wr(12'h002, m); settle;
      rd(12'h002, v); check("R4 pattern mask", v, m);
      rd(12'h000, v); check("R3 pattern vec", v, exp_vec(s & m));
      check("R2 pattern irq", {15'b0, irq}, {15'b0, (s & m) != 16'h0});
    end

    // R6 unmapped reads and ignored writes
    wr(12'h002, 16'h00F0); src = 16'h0020; settle;
    rd(12'h004, v); check("R6 rd 004", v, 16'h0);
    rd(12'h001, v); check("R6 rd 001", v, 16'h0);
    rd(12'h003, v); check("R6 rd 003", v, 16'h0);
    rd(12'h802, v); check("R6 rd 802", v, 16'h0);
    rd(12'hFFE, v); check("R6 rd FFE", v, 16'h0);
    wr(12'h000, 16'h0000); settle;
    rd(12'h002, v); check("R6 wr 000 mask", v, 16'h00F0);
    check("R6 wr 000 irq", {15'b0, irq}, 16'h1);
    wr(12'h006, 16'h0000); settle;
    rd(12'h002, v); check("R6 wr 006 mask", v, 16'h00F0);
    check("R6 wr 006 irq", {15'b0, irq}, 16'h1);

    // R7 latency of a request change
    wr(12'h002, 16'hFFFF); src = 16'h0; settle;
    src = 16'h0080;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(12'h000, v); check("R7 vec at 2", v, 16'h0);
    @(posedge clk); @(negedge clk);
    rd(12'h000, v); check("R7 vec at 3", v, 16'h0020);
    check("R7 irq at 3", {15'b0, irq}, 16'h0);
    @(posedge clk); @(negedge clk);
    check("R7 irq at 4", {15'b0, irq}, 16'h1);

    // R7 latency of a mask write
    wr(12'h002, 16'h0000);
    rd(12'h002, v); check("R7 mask at 1", v, 16'h0);
    check("R7 irq at 1", {15'b0, irq}, 16'h1);
    @(posedge clk); @(negedge clk);
    check("R7 irq at 2", {15'b0, irq}, 16'h0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule